// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one of three access kinds: data read, data write or instruction fetch. Each request goes through three stages in a fixed order. The first stage decodes the fixed address windows, which are never translated. The second checks the translation-enable control bit. The last is a fully associative match against a table of page entries. The table supports four page sizes, address-space identifiers and a shared-page override.

A matching entry is checked against the privilege level and the access kind. The result is then either a physical address with an access-rights mask or a numeric fault code. When a request faults, the unit captures the faulting address and the page-number field of the translation-entry-high register. The page table is loaded one entry at a time through an index/entry write port.

The decision is combinational. It is registered into a response that appears one cycle after the request.

Top module: `vaddr_xlate`

## Requirements
- R1: A privileged address in 0x80000000..0xBFFFFFFF translates to address AND 0x1FFFFFFF, and an address at or above 0xE0000000 passes through unchanged. Neither uses the table, and both get rights 3'b111 (bit0 read, bit1 write, bit2 execute).
- R2: In user mode (`priv`=0), an address in those fixed windows is accepted only in 0xE0000000..0xE3FFFFFF. Any other such address is an address error: code 0x100 for a write (kind 2'b01), and code 0x0E0 for a read (2'b00) or a fetch (2'b10). Kind 2'b11 behaves as a read.
- R3: For any other address, when `ctl_at` is 0, the physical address is address AND 0x1FFFFFFF with rights 3'b111.
- R4: With `ctl_at`=1, an entry covers a page whose size is set by its size code: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. The page base is VPN<<10 aligned down to the page size. On success the physical address is (PPN<<10 aligned down to the page size) OR the in-page offset bits of the address.
- R5: The ASID is compared unless `ctl_sv`=1 and `priv`=1. An entry with its shared bit set matches any ASID.
- R6: An entry whose valid bit is 0 never matches. When no entry matches, the fault is 0x060 for a write and 0x040 for a read or fetch.
- R7: When two or more entries match, the fault is 0x140, whatever the protection bits say.
- R8: A user access to an entry whose protection bit 1 is 0 gives fault 0x0C0 for a write and 0x0A0 for a read or fetch.
- R9: When R8 does not apply, a write to an entry whose protection bit 0 is 0 gives 0x0C0. Otherwise, a write to an entry whose dirty bit is 0 gives 0x080.
- R10: A successful table translation grants rights 3'b100 for a fetch. For a read or write it grants read, plus write when protection bit 0 and dirty are both 1.
- R11: On any fault, `fault_addr` takes the full virtual address. `pteh_vpn` takes address bits 31:10 on every fault except 0x140. On a success, both hold their values.
- R12: The response is registered. `rsp_valid` follows `req_valid` by one cycle, `rsp_fault` is 0 on success, and reset clears `rsp_valid`, `fault_addr` and `pteh_vpn`.
- R13: A table write at one clock edge takes effect for a request presented in the next cycle. Writing an entry replaces all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| priv | input | 1 | Privileged mode |
| ctl_at | input | 1 | Translation enable |
| ctl_sv | input | 1 | Privileged accesses ignore ASID |
| cur_asid | input | 8 | Current address-space identifier |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | IDX_W | Entry index written |
| tw_valid | input | 1 | Entry valid |
| tw_shared | input | 1 | Entry shared across ASIDs |
| tw_dirty | input | 1 | Entry dirty |
| tw_prot | input | 2 | Protection: bit1 user access, bit0 writable |
| tw_size | input | 2 | Page-size code |
| tw_asid | input | 8 | Entry ASID |
| tw_vpn | input | 22 | Virtual page number (address bits 31:10) |
| tw_ppn | input | 19 | Physical page number (physical bits 28:10) |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights, bit0 R, bit1 W, bit2 X |
| rsp_fault | output | 12 | Fault code, 0 on success |
| fault_addr | output | 32 | Last faulting virtual address |
| pteh_vpn | output | 22 | Page-number field captured on faults |

## Verification
The bench builds the unit with a four-entry table. That is small enough to sweep every combination of access kind, privilege, ASID-ignore, translation enable and two ASIDs over sixteen addresses. The addresses sit on page boundaries, in the fixed windows and at the edges of the user window. With four entries, one table setup can hold every page size, a shared entry, a non-aligned VPN and PPN, and entries with dirty or protection bits clear. A second sweep rewrites one entry so that it overlaps another, which brings the multi-hit fault and its distinct capture behaviour into reach.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int VA_W   = 32;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } pte_t;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  localparam logic [CODE_W-1:0] FC_NONE      = 12'h000;
  localparam logic [CODE_W-1:0] FC_MISS_RD   = 12'h040;
  localparam logic [CODE_W-1:0] FC_MISS_WR   = 12'h060;
  localparam logic [CODE_W-1:0] FC_FIRST_WR  = 12'h080;
  localparam logic [CODE_W-1:0] FC_PROT_RD   = 12'h0A0;
  localparam logic [CODE_W-1:0] FC_PROT_WR   = 12'h0C0;
  localparam logic [CODE_W-1:0] FC_ADDR_RD   = 12'h0E0;
  localparam logic [CODE_W-1:0] FC_ADDR_WR   = 12'h100;
  localparam logic [CODE_W-1:0] FC_MULTI     = 12'h140;

  function automatic logic [VA_W-1:0] page_offs_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   page_offs_mask = 32'h0000_03FF;
      2'b01:   page_offs_mask = 32'h0000_0FFF;
      2'b10:   page_offs_mask = 32'h0000_FFFF;
      default: page_offs_mask = 32'h000F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/xlate_area.sv
module xlate_area
  import xlate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic            priv,
  output logic            fixed,
  output logic            user_bad,
  output logic [VA_W-1:0] fixed_pa
);
  logic in_p12;
  logic in_p4;
  logic in_user_win;

  assign in_p12      = (vaddr[31:30] == 2'b10);
  assign in_p4       = (vaddr[31:29] == 3'b111);
  assign in_user_win = (vaddr[31:26] == 6'b111000);

  assign fixed    = in_p12 | in_p4;
  assign user_bad = fixed & ~priv & ~in_user_win;
  assign fixed_pa = in_p12 ? {3'b000, vaddr[28:0]} : vaddr;
endmodule

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  pte_t             wdata,
  output pte_t             ent [DEPTH]
);
  pte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign ent[g] = mem[g];
  end

  p_write_lands_r13: assert property (@(posedge clk) disable iff (rst)
    we |=> ent[$past(widx)] == $past(wdata));
endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic              use_asid,
  input  pte_t              ent [DEPTH],
  output logic              hit_any,
  output logic              hit_multi,
  output logic [PPN_W-1:0]  sel_ppn,
  output logic [1:0]        sel_size,
  output logic [1:0]        sel_prot,
  output logic              sel_dirty
);
  logic [DEPTH-1:0] hits;
  logic [CNT_W-1:0] nhits;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [VA_W-1:0] keep;
    logic            asid_ok;
    assign keep    = ~page_offs_mask(ent[g].size);
    assign asid_ok = ent[g].shared | ~use_asid | (ent[g].asid == asid);
    assign hits[g] = ent[g].valid & asid_ok &
                     ((vaddr & keep) == ({ent[g].vpn, 10'b0} & keep));
  end

  always_comb begin
    nhits     = '0;
    sel_ppn   = '0;
    sel_size  = '0;
    sel_prot  = '0;
    sel_dirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      nhits = nhits + CNT_W'(hits[i]);
      if (hits[i]) begin
        sel_ppn   = sel_ppn   | ent[i].ppn;
        sel_size  = sel_size  | ent[i].size;
        sel_prot  = sel_prot  | ent[i].prot;
        sel_dirty = sel_dirty | ent[i].dirty;
      end
    end
  end

  assign hit_any   = |hits;
  assign hit_multi = (nhits > CNT_W'(1));

  always_comb begin
    if (!hit_multi) p_single_onehot_r7: assert ($onehot0(hits));
  end
endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import xlate_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              priv,
  input  logic              ctl_at,
  input  logic              ctl_sv,
  input  logic [7:0]        cur_asid,
  input  logic              tw_en,
  input  logic [IDX_W-1:0]  tw_idx,
  input  logic              tw_valid,
  input  logic              tw_shared,
  input  logic              tw_dirty,
  input  logic [1:0]        tw_prot,
  input  logic [1:0]        tw_size,
  input  logic [7:0]        tw_asid,
  input  logic [21:0]       tw_vpn,
  input  logic [18:0]       tw_ppn,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [31:0]       rsp_paddr,
  output logic [2:0]        rsp_rights,
  output logic [11:0]       rsp_fault,
  output logic [31:0]       fault_addr,
  output logic [21:0]       pteh_vpn
);
  pte_t              wentry;
  pte_t              ent [DEPTH];
  logic              fixed, user_bad;
  logic [VA_W-1:0]   fixed_pa;
  logic              hit_any, hit_multi, sel_dirty;
  logic [PPN_W-1:0]  sel_ppn;
  logic [1:0]        sel_size, sel_prot;
  logic              use_asid, is_wr, is_fetch;
  logic              nx_ok;
  logic [VA_W-1:0]   nx_pa, omask;
  logic [2:0]        nx_rights;
  logic [CODE_W-1:0] nx_fault;

  assign wentry = '{valid: tw_valid, shared: tw_shared, dirty: tw_dirty,
                    prot: tw_prot, size: tw_size, asid: tw_asid,
                    vpn: tw_vpn, ppn: tw_ppn};

  xlate_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(tw_en), .widx(tw_idx), .wdata(wentry), .ent(ent)
  );

  xlate_area u_area (
    .vaddr(req_vaddr), .priv(priv), .fixed(fixed), .user_bad(user_bad),
    .fixed_pa(fixed_pa)
  );

  assign use_asid = ~(ctl_sv & priv);

  xlate_match #(.DEPTH(DEPTH)) u_match (
    .vaddr(req_vaddr), .asid(cur_asid), .use_asid(use_asid), .ent(ent),
    .hit_any(hit_any), .hit_multi(hit_multi), .sel_ppn(sel_ppn),
    .sel_size(sel_size), .sel_prot(sel_prot), .sel_dirty(sel_dirty)
  );

  assign is_wr    = (req_kind == KIND_WRITE);
  assign is_fetch = (req_kind == KIND_FETCH);
  assign omask    = page_offs_mask(sel_size);

  // Decision order: fixed windows, enable bit, table lookup, permissions.
  always_comb begin
    nx_ok     = 1'b0;
    nx_pa     = '0;
    nx_rights = 3'b000;
    nx_fault  = FC_NONE;
    if (fixed) begin
      if (user_bad) begin
        nx_fault = is_wr ? FC_ADDR_WR : FC_ADDR_RD;
      end else begin
        nx_ok     = 1'b1;
        nx_pa     = fixed_pa;
        nx_rights = 3'b111;
      end
    end else if (!ctl_at) begin
      nx_ok     = 1'b1;
      nx_pa     = {3'b000, req_vaddr[28:0]};
      nx_rights = 3'b111;
    end else if (hit_multi) begin
      nx_fault = FC_MULTI;
    end else if (!hit_any) begin
      nx_fault = is_wr ? FC_MISS_WR : FC_MISS_RD;
    end else if (!priv && !sel_prot[1]) begin
      nx_fault = is_wr ? FC_PROT_WR : FC_PROT_RD;
    end else if (is_wr && !sel_prot[0]) begin
      nx_fault = FC_PROT_WR;
    end else if (is_wr && !sel_dirty) begin
      nx_fault = FC_FIRST_WR;
    end else begin
      nx_ok     = 1'b1;
      nx_pa     = ({3'b000, sel_ppn, 10'b0} & ~omask) | (req_vaddr & omask);
      nx_rights = is_fetch ? 3'b100 : {1'b0, sel_prot[0] & sel_dirty, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_paddr  <= '0;
      rsp_rights <= '0;
      rsp_fault  <= '0;
      fault_addr <= '0;
      pteh_vpn   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok     <= nx_ok;
        rsp_paddr  <= nx_pa;
        rsp_rights <= nx_rights;
        rsp_fault  <= nx_fault;
        if (!nx_ok) begin
          fault_addr <= req_vaddr;
          if (nx_fault != FC_MULTI) pteh_vpn <= req_vaddr[31:10];
        end
      end
    end
  end

  p_resp_follows_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_resp_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_fault_capture_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_ok || fault_addr == $past(req_vaddr)));
  p_user_window_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv && req_vaddr[31] && req_vaddr[31:30] != 2'b11)
    |=> (!rsp_ok && rsp_fault != FC_NONE));
  p_multi_keeps_vpn_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FC_MULTI) |-> $stable(pteh_vpn));
endmodule

// File: tb/test_vaddr_xlate.sv
`timescale 1ns/1ps
module test_vaddr_xlate;
  localparam int DEPTH = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, priv, ctl_at, ctl_sv;
  logic [31:0] req_vaddr;
  logic [1:0] req_kind;
  logic [7:0] cur_asid;
  logic tw_en, tw_valid, tw_shared, tw_dirty;
  logic [IW-1:0] tw_idx;
  logic [1:0] tw_prot, tw_size;
  logic [7:0] tw_asid;
  logic [21:0] tw_vpn;
  logic [18:0] tw_ppn;
  logic rsp_valid, rsp_ok;
  logic [31:0] rsp_paddr, fault_addr;
  logic [2:0] rsp_rights;
  logic [11:0] rsp_fault;
  logic [21:0] pteh_vpn;

  always #2.5 clk = ~clk;

  vaddr_xlate #(.DEPTH(DEPTH)) i_vaddr_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .priv(priv), .ctl_at(ctl_at), .ctl_sv(ctl_sv),
    .cur_asid(cur_asid), .tw_en(tw_en), .tw_idx(tw_idx), .tw_valid(tw_valid),
    .tw_shared(tw_shared), .tw_dirty(tw_dirty), .tw_prot(tw_prot),
    .tw_size(tw_size), .tw_asid(tw_asid), .tw_vpn(tw_vpn), .tw_ppn(tw_ppn),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
    .rsp_rights(rsp_rights), .rsp_fault(rsp_fault), .fault_addr(fault_addr),
    .pteh_vpn(pteh_vpn)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side table image
  logic        m_v [DEPTH], m_sh [DEPTH], m_d [DEPTH];
  logic [1:0]  m_pr [DEPTH], m_sz [DEPTH];
  logic [7:0]  m_asid [DEPTH];
  logic [21:0] m_vpn [DEPTH];
  logic [18:0] m_ppn [DEPTH];
  logic [31:0] exp_faddr = 0;
  logic [21:0] exp_pvpn = 0;

  function automatic longint pg_bytes(input logic [1:0] sz);
    case (sz)
      2'd0: return 1024;
      2'd1: return 4096;
      2'd2: return 65536;
      default: return 1048576;
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [1:0] k,
                       input logic p, input logic at, input logic sv,
                       input logic [7:0] asid, output logic ok,
                       output logic [11:0] fc, output logic [31:0] pa,
                       output logic [2:0] rt, output string tag);
    longint ua = a;
    bit wr = (k == 2'b01);
    int nh = 0;
    int hi = 0;
    ok = 0; fc = 0; pa = 0; rt = 0; tag = "";
    if ((ua >= 64'h8000_0000 && ua < 64'hC000_0000) || ua >= 64'hE000_0000) begin
      if (!p && !(ua >= 64'hE000_0000 && ua < 64'hE400_0000)) begin
        fc = wr ? 12'h100 : 12'h0E0; tag = "R2"; return;
      end
      ok = 1; rt = 3'b111; tag = "R1";
      pa = (ua < 64'hC000_0000) ? 32'(ua % 64'h2000_0000) : a;
      return;
    end
    if (!at) begin
      ok = 1; rt = 3'b111; tag = "R3"; pa = 32'(ua % 64'h2000_0000); return;
    end
    for (int i = 0; i < DEPTH; i++) begin
      longint sb = pg_bytes(m_sz[i]);
      longint base = (longint'(m_vpn[i]) * 1024) / sb * sb;
      bit am = m_sh[i] || (sv && p) || (m_asid[i] == asid);
      if (m_v[i] && am && ua >= base && ua < base + sb) begin
        nh++; hi = i;
      end
    end
    if (nh > 1) begin fc = 12'h140; tag = "R7"; return; end
    if (nh == 0) begin fc = wr ? 12'h060 : 12'h040; tag = "R6"; return; end
    if (!p && !m_pr[hi][1]) begin fc = wr ? 12'h0C0 : 12'h0A0; tag = "R8"; return; end
    if (wr && !m_pr[hi][0]) begin fc = 12'h0C0; tag = "R9"; return; end
    if (wr && !m_d[hi]) begin fc = 12'h080; tag = "R9"; return; end
    begin
      longint sb = pg_bytes(m_sz[hi]);
      longint pb = (longint'(m_ppn[hi]) * 1024) / sb * sb;
      pa = 32'(pb + (ua % sb));
    end
    ok = 1; tag = "R4 R5 R10";
    rt = (k == 2'b10) ? 3'b100 : {1'b0, m_pr[hi][0] & m_d[hi], 1'b1};
  endtask

  task automatic load(input int idx, input logic v, input logic sh,
                      input logic d, input logic [1:0] pr, input logic [1:0] sz,
                      input logic [7:0] as, input logic [21:0] vpn,
                      input logic [18:0] ppn);
    @(negedge clk);
    tw_en = 1; tw_idx = IW'(idx); tw_valid = v; tw_shared = sh; tw_dirty = d;
    tw_prot = pr; tw_size = sz; tw_asid = as; tw_vpn = vpn; tw_ppn = ppn;
    @(posedge clk);
    #1 tw_en = 0;
    m_v[idx] = v; m_sh[idx] = sh; m_d[idx] = d; m_pr[idx] = pr;
    m_sz[idx] = sz; m_asid[idx] = as; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] k,
                       input logic p, input logic at, input logic sv,
                       input logic [7:0] asid);
    logic eok; logic [11:0] efc; logic [31:0] epa; logic [2:0] ert;
    string tag;
    bit bad;
    model(a, k, p, at, sv, asid, eok, efc, epa, ert, tag);
    if (!eok) begin
      exp_faddr = a;
      if (efc != 12'h140) exp_pvpn = a[31:10];
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = a; req_kind = k; priv = p;
    ctl_at = at; ctl_sv = sv; cur_asid = asid;
    @(posedge clk);
    #1;
    req_valid = 0;
    n_chk++;
    bad = (rsp_valid !== 1'b1) || (rsp_ok !== eok) || (rsp_fault !== efc) ||
          (eok && (rsp_paddr !== epa || rsp_rights !== ert)) ||
          (fault_addr !== exp_faddr) || (pteh_vpn !== exp_pvpn);
    if (bad) begin
      n_bad++;
      $display("FAIL %s R11 R12 va=%h kind=%0d priv=%0d at=%0d sv=%0d asid=%h actual v=%b ok=%b fc=%h pa=%h rt=%b fa=%h pv=%h expected ok=%b fc=%h pa=%h rt=%b fa=%h pv=%h",
               tag, a, k, p, at, sv, asid, rsp_valid, rsp_ok, rsp_fault,
               rsp_paddr, rsp_rights, fault_addr, pteh_vpn, eok, efc, epa,
               ert, exp_faddr, exp_pvpn);
    end
  endtask

  task automatic sweep();
    logic [31:0] addrs [16];
    logic [7:0] asids [2];
    addrs = '{32'h0040_0123, 32'h0040_1123, 32'h0080_07FF, 32'h0080_0800,
              32'h0001_ABCD, 32'h0002_0000, 32'h0017_8888, 32'h8000_1234,
              32'hA0FF_FFF0, 32'hC000_0010, 32'hE000_0040, 32'hE3FF_FFFC,
              32'hE400_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h5F00_0000};
    asids = '{8'h05, 8'h07};
    foreach (addrs[ai])
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 2; p++)
          for (int at = 0; at < 2; at++)
            for (int sv = 0; sv < 2; sv++)
              foreach (asids[si])
                apply(addrs[ai], 2'(k), 1'(p), 1'(at), 1'(sv), asids[si]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_sh[i] = 0; m_d[i] = 0; m_pr[i] = 0; m_sz[i] = 0;
      m_asid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    rst = 1; req_valid = 0; req_vaddr = 0; req_kind = 0; priv = 0;
    ctl_at = 0; ctl_sv = 0; cur_asid = 0; tw_en = 0; tw_idx = 0;
    tw_valid = 0; tw_shared = 0; tw_dirty = 0; tw_prot = 0; tw_size = 0;
    tw_asid = 0; tw_vpn = 0; tw_ppn = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R12: reset state
    n_chk++;
    if (rsp_valid !== 0 || fault_addr !== 0 || pteh_vpn !== 0) begin
      n_bad++;
      $display("FAIL R12 reset actual v=%b fa=%h pv=%h expected 0 0 0",
               rsp_valid, fault_addr, pteh_vpn);
    end
    // R13: table image loaded before translation requests
    load(0, 1, 0, 1, 2'b11, 2'b01, 8'h05, 22'h1003, 19'h12345); // 4K, unaligned VPN/PPN
    load(1, 1, 1, 1, 2'b10, 2'b10, 8'h09, 22'h0040, 19'h00777); // 64K shared, read-only
    load(2, 1, 0, 0, 2'b01, 2'b11, 8'h07, 22'h0400, 19'h7FC01); // 1M, priv-only, clean
    load(3, 1, 0, 1, 2'b11, 2'b00, 8'h05, 22'h2001, 19'h00ABC); // 1K
    sweep();
    // R12: idle cycle gives no response
    @(negedge clk);
    @(posedge clk); #1;
    n_chk++;
    if (rsp_valid !== 0) begin
      n_bad++;
      $display("FAIL R12 idle actual v=%b expected 0", rsp_valid);
    end
    // R7 and R13: overlapping entry rewritten, then removed (R6)
    load(3, 1, 0, 1, 2'b11, 2'b00, 8'h05, 22'h1000, 19'h00ABC);
    sweep();
    load(3, 0, 1, 1, 2'b11, 2'b00, 8'h05, 22'h1000, 19'h00ABC);
    apply(32'h0040_0123, 2'b00, 1, 1, 0, 8'h05);
    apply(32'h0040_0123, 2'b01, 0, 1, 0, 8'h07);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule